// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels, each stored as a high byte and a low byte. A shared 8-bit control register gives each channel a 4-bit control nibble that picks its count source (machine-cycle strobe or falling edges on an external count pin), turns pin gating on or off, and selects one of four counting structures. These are a 13-bit count through a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads itself from the high byte, and a split arrangement. In the split arrangement channel 0 becomes two independent 8-bit counters and takes over the run bit and the overflow flag of channel 1.

Each overflow sets a sticky flag that stays set until its clear input is pulsed. Software loads the count bytes through a single write port. The counts and flags are visible as plain outputs. External count and gate pins pass through a two-stage synchronizer. Count-pin edges are sampled once per machine cycle, so one count needs at least two strobes. When gating is on and the gate pin is held high, the block measures pulse width.

Top module: `dual_tmr_ctr`

## Requirements
- R1: In timer function, an enabled channel advances by one on each clock where `tick_i` is high, and never on a clock where it is low.
- R2: In counter function (nibble bit 2 = 1), the count pin is sampled after synchronization at each `tick_i`. A 1 at one strobe followed by a 0 at the next gives exactly one count. A steady pin gives no count.
- R3: Mode 0 counts the 13-bit value {high byte, low byte bits 4:0}. Low byte bits 7:5 keep their value. Wrapping from all ones to zero sets the channel's flag.
- R4: Mode 1 counts the full 16-bit value {high, low}. Wrapping from 16'hFFFF to zero sets the channel's flag.
- R5: Mode 2 counts the low byte only. When it steps past 8'hFF it is loaded with the high byte and the flag is set. The high byte is never changed by counting.
- R6: With the gate bit (nibble bit 3) set, a channel counts only while its run bit is 1 and its synchronized gate pin is high. With the gate bit clear, the gate pin has no effect.
- R7: A channel whose run bit is 0 holds its count, except channel 1 while channel 0 is in mode 3 (see R9).
- R8: With channel 0 in mode 3, its low byte counts 8 bits under channel 0's run, gate and source controls and sets flag 0. Its high byte counts `tick_i` strobes whenever `run_i[1]` is 1 and sets flag 1 on wrap.
- R9: While channel 0 is in mode 3, channel 1 counts in its own mode as if its run bit were set, and its overflow does not set flag 1.
- R10: A channel 1 set to mode 3 holds its count.
- R11: A flag stays set until its `flag_clr_i` bit is pulsed. An overflow in the same clock as a clear leaves the flag set.
- R12: The control byte holds channel 0 in bits 3:0 and channel 1 in bits 7:4. Each nibble is {gate, counter select, mode[1:0]}. Reset clears the control byte, all counts and both flags.
- R13: `cnt_sel_i` picks the byte to write: bit 1 is the channel and bit 0 selects the high byte. A write wins over counting in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| run_i | input | 2 | Run bits, one per channel |
| mode_wr_i | input | 1 | Write strobe for the control byte |
| mode_wdata_i | input | 8 | New control byte |
| cnt_wr_i | input | 1 | Write strobe for a count byte |
| cnt_sel_i | input | 2 | Count byte select {channel, high} |
| cnt_wdata_i | input | 8 | Count byte write data |
| flag_clr_i | input | 2 | Flag clear pulses, one per channel |
| ovf_o | output | 2 | Sticky overflow flags |
| cnt0_o | output | 16 | Channel 0 count {high, low} |
| cnt1_o | output | 16 | Channel 1 count {high, low} |

## Verification
The assertions assume that `tick_i` is a single-clock pulse. They also assume that count writes, control writes and flag clears are pulses handled by the same cycle-level rules as counting, so a write cycle is excluded from each hold check. The stimulus raises `tick_i` for one clock in every three. It changes pins only on falling clock edges and waits at least three clocks after a gate change before relying on it, which covers the two-stage synchronizer delay. Count-pin toggling is never faster than one level per machine cycle, so every intended edge falls within the sampling the design promises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_PRE13   = 2'd0,
    TM_FULL16  = 2'd1,
    TM_RELOAD8 = 2'd2,
    TM_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int unsigned CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cnt_pin_i,
  input  logic gate_pin_i,
  output logic gate_lvl_o,
  output logic cnt_fall_o
);
  logic [STAGES-1:0] cnt_sq, gate_sq;
  logic              smp_q;
  logic              cnt_lvl;

  assign cnt_lvl = cnt_sq[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_sq  <= '1;
      gate_sq <= '1;
      smp_q   <= 1'b1;
    end else begin
      cnt_sq  <= {cnt_sq[STAGES-2:0], cnt_pin_i};
      gate_sq <= {gate_sq[STAGES-2:0], gate_pin_i};
      if (tick_i) smp_q <= cnt_lvl;
    end
  end

  assign gate_lvl_o = gate_sq[STAGES-1];
  // edge seen between two successive strobes
  assign cnt_fall_o = tick_i & smp_q & ~cnt_lvl;

  // R2
  two_tick_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_fall_o |=> !cnt_fall_o);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PRE_W     = 5,
  parameter bit          HAS_SPLIT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              aux_inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              wrap_o,
  output logic              aux_wrap_o
);
  localparam int unsigned W13 = BYTE_W + PRE_W;
  localparam int unsigned W16 = 2 * BYTE_W;
  localparam logic [W13:0]    INC13 = 1;
  localparam logic [W16:0]    INC16 = 1;
  localparam logic [BYTE_W:0] INC9  = 1;
  localparam logic [BYTE_W-1:0] INC8 = 1;

  logic [BYTE_W-1:0] hi_q, lo_q, hi_n, lo_n;
  logic              wrap, aux_wrap;

  always_comb begin
    hi_n     = hi_q;
    lo_n     = lo_q;
    wrap     = 1'b0;
    aux_wrap = 1'b0;
    unique case (mode_i)
      TM_PRE13: if (inc_i)
        {wrap, hi_n, lo_n[PRE_W-1:0]} = {1'b0, hi_q, lo_q[PRE_W-1:0]} + INC13;
      TM_FULL16: if (inc_i)
        {wrap, hi_n, lo_n} = {1'b0, hi_q, lo_q} + INC16;
      TM_RELOAD8: if (inc_i) begin
        if (lo_q == '1) begin
          lo_n = hi_q;
          wrap = 1'b1;
        end else begin
          lo_n = lo_q + INC8;
        end
      end
      TM_SPLIT: if (HAS_SPLIT) begin
        if (inc_i)     {wrap, lo_n}     = {1'b0, lo_q} + INC9;
        if (aux_inc_i) {aux_wrap, hi_n} = {1'b0, hi_q} + INC9;
      end
      default: ;
    endcase
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  assign hi_o       = hi_q;
  assign lo_o       = lo_q;
  assign wrap_o     = wrap;
  assign aux_wrap_o = aux_wrap;

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_RELOAD8 && inc_i && lo_q == '1 && !wr_lo_i) |=> lo_q == $past(hi_q));
  // R5
  reload_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_RELOAD8 && !wr_hi_i) |=> $stable(hi_q));
  // R3
  pre_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_PRE13 && !wr_lo_i) |=> lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W]));
  // R4
  full_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_FULL16 && !inc_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [1:0]            cnt_pin_i,
  input  logic [1:0]            gate_pin_i,
  input  logic [1:0]            run_i,
  input  logic                  mode_wr_i,
  input  logic [2*CTL_W-1:0]    mode_wdata_i,
  input  logic                  cnt_wr_i,
  input  logic [1:0]            cnt_sel_i,
  input  logic [BYTE_W-1:0]     cnt_wdata_i,
  input  logic [1:0]            flag_clr_i,
  output logic [1:0]            ovf_o,
  output logic [2*BYTE_W-1:0]   cnt0_o,
  output logic [2*BYTE_W-1:0]   cnt1_o
);
  localparam int unsigned NCH = 2;

  tmr_ctl_t [NCH-1:0] ctl_q;
  logic     [NCH-1:0] gate_lvl, cnt_fall, run_eff, cnt_en, inc, wrap, aux_wrap, set;
  logic     [NCH-1:0] flag_q;
  logic [BYTE_W-1:0]  hi_w [NCH];
  logic [BYTE_W-1:0]  lo_w [NCH];
  logic               split, aux_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctl_q <= '0;
    else if (mode_wr_i) ctl_q <= mode_wdata_i;
  end

  assign split   = (ctl_q[0].mode == TM_SPLIT);
  assign aux_inc = split & run_i[1] & tick_i;
  // split mode lends channel 1's run bit to channel 0's high byte
  assign run_eff = {split | run_i[1], run_i[0]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_pin_i  (cnt_pin_i[i]),
      .gate_pin_i (gate_pin_i[i]),
      .gate_lvl_o (gate_lvl[i]),
      .cnt_fall_o (cnt_fall[i])
    );

    assign cnt_en[i] = run_eff[i] & (~ctl_q[i].gate | gate_lvl[i]);
    assign inc[i]    = cnt_en[i] & (ctl_q[i].ext ? cnt_fall[i] : tick_i);

    tmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(i == 0)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (ctl_q[i].mode),
      .inc_i      (inc[i]),
      .aux_inc_i  ((i == 0) ? aux_inc : 1'b0),
      .wr_lo_i    (cnt_wr_i && cnt_sel_i[1] == 1'(i) && !cnt_sel_i[0]),
      .wr_hi_i    (cnt_wr_i && cnt_sel_i[1] == 1'(i) &&  cnt_sel_i[0]),
      .wdata_i    (cnt_wdata_i),
      .hi_o       (hi_w[i]),
      .lo_o       (lo_w[i]),
      .wrap_o     (wrap[i]),
      .aux_wrap_o (aux_wrap[i])
    );

    // R11
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !flag_clr_i[i]) |=> flag_q[i]);
  end

  assign set[0] = wrap[0];
  assign set[1] = split ? aux_wrap[0] : (wrap[1] | aux_wrap[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr_i) | set;
  end

  assign ovf_o  = flag_q;
  assign cnt0_o = {hi_w[0], lo_w[0]};
  assign cnt1_o = {hi_w[1], lo_w[1]};

  // R10
  ch1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[1].mode == TM_SPLIT && !(cnt_wr_i && cnt_sel_i[1])) |=> $stable(cnt1_o));
  // R6
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[0].gate && !gate_lvl[0] && !split && !(cnt_wr_i && !cnt_sel_i[1]))
      |=> $stable(cnt0_o));
  // R9
  split_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && !flag_q[1] && !(run_i[1] && tick_i)) |=> !flag_q[1]);
endmodule

// File: tb/sim_dual_tmr_ctr.sv
module sim_dual_tmr_ctr;
  typedef struct packed {
    logic [7:0] md;
    logic [7:0] ph, pl, n, eh, el;
    logic       ef;
    logic [3:0] rq;
  } vec_t;

  // table entries use control byte with channel 0 nibble only
  localparam vec_t VECS [8] = '{
    '{8'h01, 8'h12, 8'h34, 8'd5, 8'h12, 8'h39, 1'b0, 4'd1},  // R1, R6 gate off with pin low
    '{8'h01, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1, 4'd4},  // R4 wrap
    '{8'h00, 8'h00, 8'h1E, 8'd3, 8'h01, 8'h01, 1'b0, 4'd3},  // R3 prescaler carry
    '{8'h00, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'hE0, 1'b1, 4'd3},  // R3 wrap, bits 7:5 kept
    '{8'h02, 8'hF0, 8'hFE, 8'd4, 8'hF0, 8'hF2, 1'b1, 4'd5},  // R5 reload
    '{8'h02, 8'h80, 8'h10, 8'd7, 8'h80, 8'h17, 1'b0, 4'd5},  // R5 no reload
    '{8'h03, 8'h00, 8'hFD, 8'd3, 8'h00, 8'h00, 1'b1, 4'd8},  // R8 low byte split
    '{8'h01, 8'hAB, 8'hCD, 8'd0, 8'hAB, 8'hCD, 1'b0, 4'd1}   // R1 no strobe
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  cnt_pin = 2'b11, gate_pin = 2'b11, run = 2'b00;
  logic        mode_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0]  mode_wdata = '0, cnt_wdata = '0;
  logic [1:0]  cnt_sel = '0, flag_clr = '0;
  logic [1:0]  ovf;
  logic [15:0] cnt0, cnt1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dual_tmr_ctr u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .gate_pin_i(gate_pin), .run_i(run), .mode_wr_i(mode_wr),
    .mode_wdata_i(mode_wdata), .cnt_wr_i(cnt_wr), .cnt_sel_i(cnt_sel),
    .cnt_wdata_i(cnt_wdata), .flag_clr_i(flag_clr), .ovf_o(ovf),
    .cnt0_o(cnt0), .cnt1_o(cnt1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] b);
    mode_wr = 1'b1; mode_wdata = b;
    @(negedge clk) mode_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [1:0] sel, input logic [7:0] d);
    cnt_wr = 1'b1; cnt_sel = sel; cnt_wdata = d;
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11;
    @(negedge clk) flag_clr = 2'b00;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R12 reset state
    check("R12 cnt0", cnt0, 16'h0000);
    check("R12 cnt1", cnt1, 16'h0000);
    check("R12 flags", ovf, 2'b00);

    gate_pin = 2'b00;
    for (int v = 0; v < 8; v++) begin
      wr_mode(VECS[v].md);
      wr_cnt(2'd0, VECS[v].pl);
      wr_cnt(2'd1, VECS[v].ph);
      clr_flags();
      run = 2'b01;
      step(int'(VECS[v].n));
      run = 2'b00;
      check($sformatf("R%0d vec%0d count", VECS[v].rq, v), cnt0, {VECS[v].eh, VECS[v].el});
      check($sformatf("R%0d vec%0d flag", VECS[v].rq, v), ovf[0], VECS[v].ef);
    end
    gate_pin = 2'b11;

    // R1 no advance between strobes
    wr_mode(8'h01); wr_cnt(2'd0, 8'h00); wr_cnt(2'd1, 8'h00);
    run = 2'b01;
    idle(5);
    check("R1 idle", cnt0, 16'h0000);
    step(2);
    check("R1 two strobes", cnt0, 16'h0002);
    // R7 run off holds
    run = 2'b00;
    step(4);
    check("R7 run off", cnt0, 16'h0002);

    // R2 counter function
    wr_mode(8'h05); wr_cnt(2'd0, 8'h00);
    run = 2'b01;
    step(5);
    check("R2 steady pin", cnt0, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      cnt_pin[0] = 1'b0; step(1);
      cnt_pin[0] = 1'b1; step(1);
    end
    check("R2 four edges", cnt0, 16'h0004);
    run = 2'b00;

    // R6 gating on channel 1
    wr_mode(8'h90); wr_cnt(2'd2, 8'h00); wr_cnt(2'd3, 8'h00);
    run = 2'b10; gate_pin = 2'b00;
    idle(3);
    step(5);
    check("R6 gate low", cnt1, 16'h0000);
    gate_pin[1] = 1'b1;
    idle(3);
    step(5);
    check("R6 gate high", cnt1, 16'h0005);
    run = 2'b00; gate_pin = 2'b11;

    // R8 and R9 split mode
    wr_mode(8'h13);
    wr_cnt(2'd1, 8'hFE); wr_cnt(2'd0, 8'h00);
    wr_cnt(2'd3, 8'hFF); wr_cnt(2'd2, 8'hFE);
    clr_flags();
    run = 2'b10;
    step(3);
    check("R8 high byte", cnt0, 16'h0100);
    check("R8 flags", ovf, 2'b10);
    check("R9 ch1 counts", cnt1, 16'h0001);
    clr_flags();
    wr_cnt(2'd3, 8'hFF); wr_cnt(2'd2, 8'hFE);
    run = 2'b00;
    step(3);
    check("R9 ch1 without run", cnt1, 16'h0001);
    check("R9 no flag", ovf, 2'b00);
    check("R8 high byte held", cnt0, 16'h0100);

    // R10 channel 1 mode 3 holds
    wr_mode(8'h31);
    wr_cnt(2'd3, 8'h12); wr_cnt(2'd2, 8'h34);
    run = 2'b11;
    step(4);
    check("R10 ch1 held", cnt1, 16'h1234);
    check("R12 ch0 nibble mode1", cnt0, 16'h0104);
    run = 2'b00;

    // R11 sticky flag
    wr_mode(8'h01); wr_cnt(2'd0, 8'hFF); wr_cnt(2'd1, 8'hFF);
    clr_flags();
    run = 2'b01;
    step(1);
    check("R11 set", ovf[0], 1'b1);
    step(2);
    check("R11 sticky", ovf[0], 1'b1);
    clr_flags();
    check("R11 cleared", ovf[0], 1'b0);
    wr_cnt(2'd0, 8'hFF); wr_cnt(2'd1, 8'hFF);
    tick = 1'b1; flag_clr = 2'b01;
    @(negedge clk) tick = 1'b0; flag_clr = 2'b00;
    check("R11 set wins", ovf[0], 1'b1);

    // R13 write beats count
    wr_cnt(2'd1, 8'h00);
    tick = 1'b1; cnt_wr = 1'b1; cnt_sel = 2'd0; cnt_wdata = 8'h55;
    @(negedge clk) tick = 1'b0; cnt_wr = 1'b0;
    check("R13 write priority", cnt0, 16'h0055);
    run = 2'b00;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule